// File: doc/BRIEF.md
# Digital Pulse-Frequency / Continuous-Conduction Boost Mode Controller

This block is the switching brain of a boost converter. It needs no error amplifier and no duty-cycle integrator. The only information it gets about the output is a pair of comparator flags: one says the output is under the lower window threshold, the other says it is over the upper one. It also receives a strobe that marks the end of the inductor ramp-down, and a shutdown request. From these inputs it drives the low-side switch (which charges the inductor) and the high-side switch (which discharges it into the output). It also reports the peak-current level it is working at and whether it is in continuous conduction.

The block has four operating levels. Levels 0 to 2 run discontinuous pulses, and each level has a longer on-time, and so a higher peak current, than the one below it. A new pulse starts only while the output is not above the upper threshold, so the pulse rate follows the load. Level 3 is continuous conduction. The switches alternate in a fixed pattern with no idle gap. When the output touches a window edge, the next on-time is doubled or halved. Every decision is made once per cycle, at the ramp-down strobe. An under-window result moves the controller up one level. An over-window result seen at a fixed number of decisions in a row moves it down one level.

Top module: `dcdc_mode_ctrl`

## Requirements
- R1: While `shutdown` is high, `hs_en` and `ls_en` are both low in the same cycle. A clock edge with `shutdown` high returns the controller to level 0 (`peak_lvl` = 0). After release it starts again from level 0.
- R2: `hs_en` and `ls_en` are never high together. Every switch from one to the other passes through exactly one clock with both low.
- R3: At level k (0, 1, 2), each low-side pulse lasts `TON_L0`, `TON_L1` or `TON_L2` clocks respectively. The defaults are 4, 8 and 12.
- R4: At a decision with `vout_low` high, a level below 3 rises by one. `peak_lvl` shows the new level in the cycle after the decision edge. `ccm_mode` is 1 exactly when `peak_lvl` is 3.
- R5: At levels 0 to 2, after a ramp-down the controller waits with both switches off. A new low-side pulse starts on an edge only if `vout_high` is low at that edge.
- R6: At level 3, each ramp-down is followed by exactly one dead clock and then the next low-side pulse, whatever the state of `vout_high`.
- R7: At level 3, the on-time is `TON_CCM` clocks (default 16). After a decision with `vout_low` high, the next on-time is 2·`TON_CCM`. After a decision with only `vout_high` high that does not step down, it is `TON_CCM`/2.
- R8: The level drops by one (staying at 0 if already there) at the `DOWN_COUNT`-th consecutive decision (default 4) where `vout_high` is high and `vout_low` is low. Any other decision clears the run. `vout_low` takes priority when both flags are high.
- R9: A decision happens only on an edge where `ramp_end` is high while the high-side switch is on. The high-side switch stays on until that strobe arrives. A strobe at any other time has no effect.
- R10: After reset both switches are off, `peak_lvl` is 0 and `ccm_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shutdown | input | 1 | Forces both switches off and the level to 0 |
| vout_low | input | 1 | Output is below the lower window threshold |
| vout_high | input | 1 | Output is above the upper window threshold |
| ramp_end | input | 1 | Strobe: inductor ramp-down finished |
| hs_en | output | 1 | High-side (discharge) switch enable |
| ls_en | output | 1 | Low-side (charge) switch enable |
| peak_lvl | output | 2 | Current operating level, 0 to 3 |
| ccm_mode | output | 1 | High in continuous conduction (level 3) |

## Verification
A level change caused by a decision is due one edge after the strobe edge. A new level-0..2 pulse rises at the earliest two edges after that decision. A level-3 pulse rises exactly two edges after it. Shutdown gating applies in the same cycle, before any edge. The bench drives inputs and samples outputs on the falling clock edge. It updates its own level and on-time prediction at the moment it drives the inputs of the next rising edge, and compares on the following falling edge. Pulse widths and dead gaps are measured as runs of consecutive samples, so each result is checked in the cycle in which it is due.

// File: rtl/dcdc_mode_ctrl.sv
module dcdc_mode_ctrl #(
  parameter int TON_L0     = 4,
  parameter int TON_L1     = 8,
  parameter int TON_L2     = 12,
  parameter int TON_CCM    = 16,
  parameter int DOWN_COUNT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shutdown,
  input  logic       vout_low,
  input  logic       vout_high,
  input  logic       ramp_end,
  output logic       hs_en,
  output logic       ls_en,
  output logic [1:0] peak_lvl,
  output logic       ccm_mode
);

  localparam int TW = $clog2(2 * TON_CCM + 1);
  localparam int DW = $clog2(DOWN_COUNT + 1);

  typedef enum logic [2:0] {PH_IDLE, PH_ON, PH_GAP_A, PH_OFF, PH_GAP_B} phase_t;
  typedef enum logic [1:0] {ADJ_NOM, ADJ_LONG, ADJ_SHORT} adj_t;

  phase_t        ph, ph_nx;
  adj_t          adj, adj_nx;
  logic [1:0]    lvl, lvl_nx;
  logic [DW-1:0] dn, dn_nx;
  logic [TW-1:0] cnt, cnt_nx, ton_sel;

  wire decide = (ph == PH_OFF) && ramp_end;

  always_comb begin
    case (lvl)
      2'd0:    ton_sel = TW'(TON_L0);
      2'd1:    ton_sel = TW'(TON_L1);
      2'd2:    ton_sel = TW'(TON_L2);
      default: ton_sel = (adj == ADJ_LONG)  ? TW'(2 * TON_CCM) :
                         (adj == ADJ_SHORT) ? TW'(TON_CCM / 2) : TW'(TON_CCM);
    endcase
  end

  always_comb begin
    lvl_nx = lvl;
    adj_nx = adj;
    dn_nx  = dn;
    if (decide) begin
      if (vout_low) begin
        dn_nx = '0;
        if (lvl != 2'd3) begin
          lvl_nx = lvl + 2'd1;
          adj_nx = ADJ_NOM;
        end else begin
          adj_nx = ADJ_LONG;
        end
      end else if (vout_high) begin
        if (dn == DW'(DOWN_COUNT - 1)) begin
          dn_nx  = '0;
          adj_nx = ADJ_NOM;
          if (lvl != 2'd0) lvl_nx = lvl - 2'd1;
        end else begin
          dn_nx  = dn + DW'(1);
          adj_nx = (lvl == 2'd3) ? ADJ_SHORT : ADJ_NOM;
        end
      end else begin
        dn_nx  = '0;
        adj_nx = ADJ_NOM;
      end
    end

    ph_nx  = ph;
    cnt_nx = cnt;
    case (ph)
      PH_IDLE: if (!vout_high) begin
        ph_nx  = PH_ON;
        cnt_nx = ton_sel - TW'(1);
        adj_nx = ADJ_NOM;
      end
      PH_ON: begin
        if (cnt == '0) ph_nx = PH_GAP_A;
        else           cnt_nx = cnt - TW'(1);
      end
      PH_GAP_A: ph_nx = PH_OFF;
      PH_OFF: if (ramp_end) ph_nx = (lvl_nx == 2'd3) ? PH_GAP_B : PH_IDLE;
      PH_GAP_B: begin
        ph_nx  = PH_ON;
        cnt_nx = ton_sel - TW'(1);
        adj_nx = ADJ_NOM;
      end
      default: ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      adj <= ADJ_NOM;
      lvl <= 2'd0;
      dn  <= '0;
      cnt <= '0;
    end else if (shutdown) begin
      ph  <= PH_IDLE;
      adj <= ADJ_NOM;
      lvl <= 2'd0;
      dn  <= '0;
      cnt <= '0;
    end else begin
      ph  <= ph_nx;
      adj <= adj_nx;
      lvl <= lvl_nx;
      dn  <= dn_nx;
      cnt <= cnt_nx;
    end
  end

  assign ls_en    = (ph == PH_ON)  & ~shutdown;
  assign hs_en    = (ph == PH_OFF) & ~shutdown;
  assign peak_lvl = lvl;
  assign ccm_mode = (lvl == 2'd3);

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) !(hs_en && ls_en)); // R2
  AST_DEAD_BEFORE_ON: assert property (@(posedge clk) disable iff (!rst_n) $rose(ls_en) |-> !$past(hs_en)); // R2
  AST_DEAD_BEFORE_OFF: assert property (@(posedge clk) disable iff (!rst_n) $rose(hs_en) |-> !$past(ls_en)); // R2
  AST_RESTART_LOW: assert property (@(posedge clk) disable iff (!rst_n) $fell(shutdown) |-> peak_lvl == 2'd0); // R1
  AST_LVL_AT_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
    (peak_lvl != $past(peak_lvl)) && !$past(shutdown) |-> $past(hs_en && ramp_end)); // R9
  AST_LVL_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (peak_lvl != $past(peak_lvl)) && !$past(shutdown) |->
      (peak_lvl == $past(peak_lvl) + 2'd1) || (peak_lvl == $past(peak_lvl) - 2'd1)); // R4

endmodule

// File: tb/test_dcdc_mode_ctrl.sv
`timescale 1ns/1ps
module test_dcdc_mode_ctrl;
  localparam int T0 = 4, T1 = 8, T2 = 12, TC = 16, NDN = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, sd = 1'b0, lo = 1'b0, hi = 1'b0, rd = 1'b0;
  wire hs, ls, ccm;
  wire [1:0] lvl;

  dcdc_mode_ctrl #(.TON_L0(T0), .TON_L1(T1), .TON_L2(T2), .TON_CCM(TC), .DOWN_COUNT(NDN)) i_dcdc_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .shutdown(sd), .vout_low(lo), .vout_high(hi), .ramp_end(rd),
    .hs_en(hs), .ls_en(ls), .peak_lvl(lvl), .ccm_mode(ccm));

  int n_chk = 0, n_fail = 0;
  int m_lvl = 0, m_adj = 0, m_dn = 0;
  int ls_run = 0, gap = 0, exp_ton = 0;
  bit prev_hs = 0, prev_ls = 0, prev_hi = 0, prev_rd = 0, run_sd = 1, ccm_fall = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ton_of(int l, int a);
    if (l == 0) return T0;
    if (l == 1) return T1;
    if (l == 2) return T2;
    if (a == 1) return 2 * TC;
    if (a == 2) return TC / 2;
    return TC;
  endfunction

  task automatic cyc(bit s, bit l, bit h, bit r);
    @(negedge clk);
    chk(lvl == 2'(m_lvl), "R4,R8 level", lvl, m_lvl);
    chk(ccm == (m_lvl == 3), "R4 ccm flag", ccm, m_lvl == 3);
    chk(!(hs && ls), "R2 overlap", hs && ls, 0);
    if (ls && !prev_ls) begin
      chk(!prev_hs, "R2 dead before on", prev_hs, 0);
      if (m_lvl < 3) chk(!prev_hi, "R5 pulse while above upper", prev_hi, 0);
      if (m_lvl == 3 && ccm_fall) chk(gap == 1, "R6 ccm gap", gap, 1);
      exp_ton = ton_of(m_lvl, m_adj);
      m_adj = 0; ls_run = 0; run_sd = 0; ccm_fall = 0;
    end
    if (ls) ls_run++;
    if (!ls && prev_ls && !run_sd) chk(ls_run == exp_ton, "R3,R7 on-time", ls_run, exp_ton);
    if (hs && !prev_hs) begin
      chk(!prev_ls, "R2 dead before off", prev_ls, 0);
      if (!run_sd) chk(gap == 1, "R2 off gap", gap, 1);
    end
    if (!hs && prev_hs && !sd) begin
      chk(prev_rd, "R9 high side held until strobe", prev_rd, 1);
      ccm_fall = (m_lvl == 3);
    end
    if (hs || ls) gap = 0; else gap++;
    prev_hs = hs; prev_ls = ls;
    sd = s; lo = l; hi = h; rd = r;
    if (s) begin
      #1;
      chk(!hs && !ls, "R1 shutdown gating", hs || ls, 0);
      m_lvl = 0; m_adj = 0; m_dn = 0; run_sd = 1; ccm_fall = 0;
    end else if (prev_hs && r) begin
      if (l) begin
        m_dn = 0;
        if (m_lvl < 3) begin m_lvl++; m_adj = 0; end else m_adj = 1;
      end else if (h) begin
        if (m_dn == NDN - 1) begin
          m_dn = 0; m_adj = 0;
          if (m_lvl > 0) m_lvl--;
        end else begin
          m_dn++; m_adj = (m_lvl == 3) ? 2 : 0;
        end
      end else begin
        m_dn = 0; m_adj = 0;
      end
    end
    prev_hi = h; prev_rd = r;
  endtask

  task automatic decide(bit l, bit h);
    for (int k = 0; k < 200 && !prev_hs; k++) cyc(0, 0, 0, 0);
    cyc(0, l, h, 1);
    cyc(0, 0, h, 0);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!hs && !ls && lvl == 2'd0 && !ccm, "R10 reset state", {hs, ls, lvl, ccm}, 0);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0);
    decide(0, 0);
    decide(1, 0);
    for (int k = 0; k < 3; k++) decide(0, 1);
    decide(0, 0);
    for (int k = 0; k < 3; k++) decide(0, 1);
    chk(lvl == 2'd1, "R8 broken run keeps level", lvl, 1);
    decide(0, 1);
    chk(lvl == 2'd0, "R8 step down after run", lvl, 0);
    decide(1, 1);
    chk(lvl == 2'd1, "R8 low wins over high", lvl, 1);
    for (int k = 0; k < 20; k++) begin
      cyc(0, 0, 1, 0);
      if (!prev_hs && !prev_ls) begin
        for (int j = 0; j < 10; j++) begin
          cyc(0, 1, 1, 1);
          chk(!ls && lvl == 2'd1, "R5,R9 idle with high flag and stray strobe", {ls, lvl}, 1);
        end
        break;
      end
    end
    for (int k = 0; k < 2; k++) decide(1, 0);
    chk(ccm && lvl == 2'd3, "R4 entry to continuous", lvl, 3);
    decide(0, 1);
    decide(1, 0);
    decide(0, 1);
    decide(0, 1);
    decide(0, 1);
    chk(lvl == 2'd3, "R8 run reset by low decision", lvl, 3);
    decide(0, 1);
    chk(lvl == 2'd2, "R8 leave continuous", lvl, 2);
    decide(1, 0);
    for (int k = 0; k < 5; k++) cyc(0, 0, 1, 0);
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0);
    chk(lvl == 2'd0, "R1 restart at level 0", lvl, 0);
    void'($urandom(32'd1205));
    for (int blk = 0; blk < 10; blk++) begin
      int plo = (blk % 3 == 0) ? 30 : 8;
      int phi = (blk % 3 == 1) ? 40 : 15;
      for (int k = 0; k < 2000; k++)
        cyc(($urandom % 400) == 0, ($urandom % 100) < plo, ($urandom % 100) < phi, ($urandom % 4) == 0);
    end
    done = 1;
    report();
  end
endmodule